// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block decides whether a pending interrupt may preempt the code a small CPU is running. It keeps the CPU's current two-bit priority level and a bank of byte-wide software priority registers, one two-bit field per maskable vector. Each cycle it compares the programmed level of every requested vector with the current level. When a request wins, the block raises a one-cycle accept pulse, reports the winning vector number and the level to enter, and loads that level as the new current level.

The two-bit level code is not monotonic. Code `10` is the lowest level (main program), then `01`, then `00`, and `11` is the highest level, where software priority is disabled. Writes to the priority registers are filtered field by field: a field written with `10` keeps its previous value. Fields that have no maskable vector behind them always read as ones. The top-level vector (vector 0), the trap input and the reset input can all interrupt code running at the highest level.

Top module: `nip_ctrl`

## Requirements
- R1: After reset, every priority register reads 0xFF, `lvl_code` is `11` (both interrupt bits set, highest level), and `acc_pulse` is low.
- R2: Vector n owns bits [2*(n%4)+1 : 2*(n%4)] of priority register n/4. A written field reads back on `reg_rdata` in the cycle after the write, with `reg_rdata` showing the register selected by `reg_addr`.
- R3: Any field written with code `10` keeps its previous value. The other fields of the same byte still take the written data.
- R4: Bits 1:0 of register 0 (vector 0) and every field of an index at or above the vector count (bits 7:4 of register 7 by default) always read `11`, whatever is written.
- R5: Codes rank as `10`=0, `01`=1, `00`=2, `11`=3. A requested maskable vector other than vector 0 is accepted only when its rank is strictly above the rank of `lvl_code`.
- R6: A request on vector 0 is accepted at any current level, including `11`, and then loads level `11`.
- R7: Among eligible maskable requests, the highest rank wins, and a tie goes to the lowest vector number.
- R8: `reset_req` outranks `trap_req`, and `trap_req` outranks all maskable vectors. Both are accepted at any level, report vector numbers 31 (reset) and 30 (trap), and load level `11`.
- R9: A request seen at a clock edge gives `acc_pulse` high for exactly one cycle after that edge, with `acc_vec` and `acc_lvl` valid in the same cycle. No request is accepted at the edge that ends an accept cycle.
- R10: On an accept, `lvl_code` takes the accepted vector's code at the same edge. Otherwise `lvl_we` loads `lvl_wdata`. An accept takes precedence over a simultaneous `lvl_we`, and without either event the level holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Priority register write strobe |
| reg_addr | input | 3 | Priority register select for write and read |
| reg_wdata | input | 8 | Write data, four two-bit fields |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_req | input | 30 | Pending maskable requests, one per vector |
| trap_req | input | 1 | Non-maskable trap request |
| reset_req | input | 1 | Reset request, highest precedence |
| lvl_we | input | 1 | Load the current level from software or return logic |
| lvl_wdata | input | 2 | Level code to load (bit 1 = I1, bit 0 = I0) |
| lvl_code | output | 2 | Current level code |
| acc_pulse | output | 1 | One-cycle accept pulse |
| acc_vec | output | 5 | Accepted vector (0..29 maskable, 30 trap, 31 reset) |
| acc_lvl | output | 2 | Level code entered by the accepted request |

## Verification
The assertions assume that the request lines are synchronous to `clk` and free of X. They also assume that a request source drops its line once it sees its accept; the block makes no such demand and only blocks one edge. The bench drives every input half a period away from the rising edge and keeps all address values inside the register bank. It lets requests linger randomly, so the one-edge block after an accept is exercised both with the line held and with it released. Level writes pick all four codes, including the lowest, so that each rank comparison is reached.

// File: rtl/nip_pkg.sv
package nip_pkg;

  typedef logic [1:0] prio_code_t;

  // Level codes, I1 in bit 1 and I0 in bit 0
  localparam prio_code_t CODE_L0 = 2'b10;  // main program, lowest
  localparam prio_code_t CODE_L1 = 2'b01;
  localparam prio_code_t CODE_L2 = 2'b00;
  localparam prio_code_t CODE_L3 = 2'b11;  // highest, software priority off

  // Map a non-monotonic code to a numeric rank 0..3
  function automatic logic [1:0] code_rank(prio_code_t c);
    case (c)
      CODE_L0: return 2'd0;
      CODE_L1: return 2'd1;
      CODE_L2: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // Per-field write filter: lowest code keeps old contents
  function automatic prio_code_t filter_field(prio_code_t old_c, prio_code_t new_c);
    if (new_c == CODE_L0) return old_c;
    return new_c;
  endfunction

endpackage

// File: rtl/nip_prio_regs.sv
module nip_prio_regs
  import nip_pkg::*;
#(
  parameter int NVEC   = 30,
  parameter int NREG   = 8,
  parameter int ADDR_W = 3,
  localparam int NFIELD = NREG * 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [7:0]                   wr_data,
  output logic [7:0]                   rd_data,
  output logic [NFIELD-1:0][1:0]       codes_o
);

  logic [NFIELD-1:0][1:0] code_q;
  logic [NREG-1:0][7:0]   reg_bytes;
  logic                   any_low;

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    localparam bit HARD = (f == 0) || (f >= NVEC);
    if (HARD) begin : g_hard
      assign code_q[f] = CODE_L3;
    end else begin : g_soft
      logic sel;
      assign sel = wr_en && (addr == ADDR_W'(f / 4));
      always_ff @(posedge clk) begin
        if (!rst_n)   code_q[f] <= CODE_L3;
        else if (sel) code_q[f] <= filter_field(code_q[f], wr_data[2*(f%4) +: 2]);
      end
      // R3: a lowest-code write leaves the field untouched
      a_r3_keep_field: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_data[2*(f%4) +: 2] == CODE_L0) |=> $stable(code_q[f]));
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_byte
    assign reg_bytes[r] = {code_q[4*r+3], code_q[4*r+2], code_q[4*r+1], code_q[4*r]};
  end

  assign rd_data = reg_bytes[addr];
  assign codes_o = code_q;

  always_comb begin
    any_low = 1'b0;
    for (int f = 0; f < NFIELD; f++) any_low = any_low | (code_q[f] == CODE_L0);
  end

  a_r3_never_lowest: assert property (@(posedge clk) disable iff (!rst_n) !any_low);
  a_r4_top_field_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (rd_data[1:0] == CODE_L3));

endmodule

// File: rtl/nip_arbiter.sv
module nip_arbiter
  import nip_pkg::*;
#(
  parameter int NVEC  = 30,
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NVEC-1:0][1:0]   codes,
  input  logic [NVEC-1:0]        irq,
  input  logic                   trap,
  input  logic                   rst_req,
  input  logic                   block,
  input  prio_code_t             cur_code,
  output logic                   pick_valid,
  output logic [IDX_W-1:0]       pick_idx,
  output prio_code_t             pick_code
);

  localparam logic [IDX_W-1:0] TRAP_IDX  = IDX_W'(NVEC);
  localparam logic [IDX_W-1:0] RESET_IDX = IDX_W'(NVEC + 1);

  logic [NVEC-1:0]       elig;
  logic [NVEC-1:0][1:0]  rank;
  logic [1:0]            cur_rank;
  logic                  found;
  logic [1:0]            best_rank;
  logic [IDX_W-1:0]      best_idx;

  assign cur_rank = code_rank(cur_code);

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    assign rank[v] = code_rank(codes[v]);
    if (v == 0) begin : g_top
      assign elig[v] = irq[v];
    end else begin : g_mask
      assign elig[v] = irq[v] && (rank[v] > cur_rank);
    end
  end

  // Ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    found     = 1'b0;
    best_rank = 2'd0;
    best_idx  = '0;
    for (int v = 0; v < NVEC; v++) begin
      if (elig[v] && (!found || rank[v] > best_rank)) begin
        found     = 1'b1;
        best_rank = rank[v];
        best_idx  = IDX_W'(v);
      end
    end
  end

  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    pick_code  = CODE_L3;
    if (!block) begin
      if (rst_req) begin
        pick_valid = 1'b1;
        pick_idx   = RESET_IDX;
      end else if (trap) begin
        pick_valid = 1'b1;
        pick_idx   = TRAP_IDX;
      end else if (found) begin
        pick_valid = 1'b1;
        pick_idx   = best_idx;
        pick_code  = codes[best_idx];
      end
    end
  end

  a_r5_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && pick_idx < TRAP_IDX && pick_idx != '0)
      |-> (code_rank(pick_code) > cur_rank));
  a_r8_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !block) |-> (pick_valid && pick_idx == RESET_IDX && pick_code == CODE_L3));
  a_r8_trap_next: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && !rst_req && !block) |-> (pick_idx == TRAP_IDX));
  a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    block |-> !pick_valid);
  a_r7_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && pick_idx < TRAP_IDX) |-> irq[pick_idx]);

endmodule

// File: rtl/nip_ctrl.sv
module nip_ctrl
  import nip_pkg::*;
#(
  parameter int NVEC = 30,
  localparam int NREG   = (NVEC + 3) / 4,
  localparam int ADDR_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int NFIELD = NREG * 4,
  localparam int IDX_W  = $clog2(NVEC + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [NVEC-1:0]    irq_req,
  input  logic               trap_req,
  input  logic               reset_req,
  input  logic               lvl_we,
  input  logic [1:0]         lvl_wdata,
  output logic [1:0]         lvl_code,
  output logic               acc_pulse,
  output logic [IDX_W-1:0]   acc_vec,
  output logic [1:0]         acc_lvl
);

  logic [NFIELD-1:0][1:0] all_codes;
  logic                   pick_valid;
  logic [IDX_W-1:0]       pick_idx;
  prio_code_t             pick_code;
  prio_code_t             cur_q;
  logic                   acc_q;
  logic [IDX_W-1:0]       vec_q;
  prio_code_t             alvl_q;

  nip_prio_regs #(.NVEC(NVEC), .NREG(NREG), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we),
    .addr    (reg_addr),
    .wr_data (reg_wdata),
    .rd_data (reg_rdata),
    .codes_o (all_codes)
  );

  nip_arbiter #(.NVEC(NVEC), .IDX_W(IDX_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .codes      (all_codes[NVEC-1:0]),
    .irq        (irq_req),
    .trap       (trap_req),
    .rst_req    (reset_req),
    .block      (acc_q),
    .cur_code   (cur_q),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx),
    .pick_code  (pick_code)
  );

  // Current level: accept beats a software load
  always_ff @(posedge clk) begin
    if (!rst_n)          cur_q <= CODE_L3;
    else if (pick_valid) cur_q <= pick_code;
    else if (lvl_we)     cur_q <= lvl_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      vec_q  <= '0;
      alvl_q <= CODE_L3;
    end else begin
      acc_q <= pick_valid;
      if (pick_valid) begin
        vec_q  <= pick_idx;
        alvl_q <= pick_code;
      end
    end
  end

  assign lvl_code  = cur_q;
  assign acc_pulse = acc_q;
  assign acc_vec   = vec_q;
  assign acc_lvl   = alvl_q;

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |=> !acc_pulse);
  a_r10_level_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |-> (lvl_code == acc_lvl));
  a_r10_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_we && !pick_valid) |=> $stable(lvl_code));
  a_r8_nmi_level: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pulse && acc_vec >= IDX_W'(NVEC)) |-> (acc_lvl == CODE_L3));

endmodule

// File: tb/test_nip_ctrl.sv
module test_nip_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [NV-1:0] irq_req = '0;
  logic        trap_req = 1'b0;
  logic        reset_req = 1'b0;
  logic        lvl_we = 1'b0;
  logic [1:0]  lvl_wdata = '0;
  logic [1:0]  lvl_code;
  logic        acc_pulse;
  logic [4:0]  acc_vec;
  logic [1:0]  acc_lvl;

  int checks = 0;
  int errors = 0;

  int m_f[32];
  int m_lvl;
  bit m_blk;

  always #(CLK_PERIOD/2) clk = ~clk;

  nip_ctrl i_nip_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .trap_req(trap_req), .reset_req(reset_req), .lvl_we(lvl_we),
    .lvl_wdata(lvl_wdata), .lvl_code(lvl_code), .acc_pulse(acc_pulse),
    .acc_vec(acc_vec), .acc_lvl(acc_lvl)
  );

  // Rank restated arithmetically: 11 -> 3, else 2 minus the code
  function automatic int rnk(int c);
    return (c == 3) ? 3 : (2 - c);
  endfunction

  function automatic int model_byte(int a);
    int b = 0;
    for (int k = 0; k < 4; k++) b = b | (m_f[a*4+k] << (2*k));
    return b;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: predict, step, compare, then release all strobes and requests
  task automatic cyc(string tag);
    int e_acc = 0, e_vec = 0, e_lvl = 3, best = -1;
    if (!m_blk) begin
      if (reset_req) begin e_acc = 1; e_vec = 31; end
      else if (trap_req) begin e_acc = 1; e_vec = 30; end
      else begin
        for (int i = 0; i < NV; i++)
          if (irq_req[i] && (i == 0 || rnk(m_f[i]) > rnk(m_lvl)))
            if (best < 0 || rnk(m_f[i]) > rnk(m_f[best])) best = i;
        if (best >= 0) begin e_acc = 1; e_vec = best; e_lvl = m_f[best]; end
      end
    end
    m_blk = (e_acc != 0);
    if (e_acc != 0) m_lvl = e_lvl;
    else if (lvl_we) m_lvl = int'(lvl_wdata);
    if (reg_we)
      for (int k = 0; k < 4; k++) begin
        int idx = int'(reg_addr) * 4 + k;
        int wf = (int'(reg_wdata) >> (2*k)) & 3;
        if (idx != 0 && idx < NV && wf != 2) m_f[idx] = wf;
      end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "acc_pulse", int'(acc_pulse), e_acc);
    if (e_acc != 0) begin
      chk(tag, "acc_vec", int'(acc_vec), e_vec);
      chk(tag, "acc_lvl", int'(acc_lvl), e_lvl);
    end
    chk(tag, "lvl_code", int'(lvl_code), m_lvl);
    chk(tag, "reg_rdata", int'(reg_rdata), model_byte(int'(reg_addr)));
    reg_we = 1'b0; lvl_we = 1'b0; irq_req = '0; trap_req = 1'b0; reset_req = 1'b0;
  endtask

  task automatic wr(int a, int d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
  endtask

  task automatic set_lvl(int c);
    lvl_we = 1'b1; lvl_wdata = 2'(c); cyc("R10");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) m_f[i] = 3;
    m_lvl = 3; m_blk = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "acc_pulse", int'(acc_pulse), 0);
    chk("R1", "lvl_code", int'(lvl_code), 3);
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a); #1;
      chk("R1", "reg_rdata", int'(reg_rdata), 8'hFF);
    end

    // R4: hardwired fields
    wr(0, 8'h00); cyc("R4"); chk("R4", "reg0", int'(reg_rdata), 8'h03);
    wr(7, 8'h00); cyc("R4"); chk("R4", "reg7", int'(reg_rdata), 8'hF0);
    // R2: field placement
    wr(2, 8'h4D); cyc("R2"); chk("R2", "reg2", int'(reg_rdata), 8'h4D);
    wr(3, 8'h3C); cyc("R2"); chk("R2", "reg3", int'(reg_rdata), 8'h3C);
    // R3: lowest code keeps the old field
    wr(2, 8'hA2); cyc("R3"); chk("R3", "reg2", int'(reg_rdata), 8'h41);
    wr(5, 8'h1B); cyc("R3"); chk("R3", "reg5", int'(reg_rdata), 8'h1F);

    // R5: strict rank comparison (v8=01, v9=00)
    set_lvl(1); chk("R10", "lvl_code", int'(lvl_code), 1);
    irq_req[8] = 1'b1; cyc("R5"); chk("R5", "equal rank", int'(acc_pulse), 0);
    irq_req[9] = 1'b1; cyc("R5"); chk("R5", "vec9", int'(acc_vec), 9);
    cyc("R5");
    // R6: vector 0 at the highest level (v12=00, v13=11)
    set_lvl(3);
    irq_req[12] = 1'b1; irq_req[13] = 1'b1; cyc("R6");
    chk("R6", "masked at top", int'(acc_pulse), 0);
    irq_req[0] = 1'b1; cyc("R6"); chk("R6", "vec0", int'(acc_vec), 0);
    cyc("R6");
    // R7: highest rank then lowest index
    set_lvl(2);
    irq_req[8] = 1'b1; irq_req[12] = 1'b1; irq_req[13] = 1'b1; irq_req[14] = 1'b1;
    cyc("R7"); chk("R7", "vec13", int'(acc_vec), 13);
    cyc("R7"); set_lvl(2);
    irq_req[12] = 1'b1; irq_req[9] = 1'b1; cyc("R7"); chk("R7", "vec9", int'(acc_vec), 9);
    cyc("R7");
    // R8: reset over trap over maskable, at the highest level
    set_lvl(3);
    irq_req = '1; trap_req = 1'b1; reset_req = 1'b1; cyc("R8");
    chk("R8", "reset vec", int'(acc_vec), 31);
    cyc("R8");
    irq_req = '1; trap_req = 1'b1; cyc("R8"); chk("R8", "trap vec", int'(acc_vec), 30);
    chk("R8", "trap lvl", int'(acc_lvl), 3);
    cyc("R8");
    // R9: one pulse, blocked edge, then no re-accept at equal level
    set_lvl(2);
    irq_req[9] = 1'b1; cyc("R9"); chk("R9", "first", int'(acc_pulse), 1);
    irq_req[9] = 1'b1; cyc("R9"); chk("R9", "blocked", int'(acc_pulse), 0);
    irq_req[9] = 1'b1; cyc("R9"); chk("R9", "same level", int'(acc_pulse), 0);
    // R10: accept beats a simultaneous level write
    set_lvl(2);
    irq_req[9] = 1'b1; lvl_we = 1'b1; lvl_wdata = 2'b01; cyc("R10");
    chk("R10", "accept wins", int'(lvl_code), 0);
    cyc("R10");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      reg_addr = 3'($urandom % 8);
      if ($urandom % 6 == 0) begin reg_we = 1'b1; reg_wdata = 8'($urandom); end
      if ($urandom % 8 == 0) begin lvl_we = 1'b1; lvl_wdata = 2'($urandom); end
      if ($urandom % 4 != 0) irq_req = NV'($urandom & $urandom & $urandom);
      trap_req = ($urandom % 40 == 0);
      reset_req = ($urandom % 80 == 0);
      cyc("R7");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule